// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A walk starts with a pulse on `start`, together with the virtual address and the translation table base. The walker issues one read for the first-level entry. That entry either ends the walk as a 1 MB section, or it points to a coarse or fine second-level table. In the second case the walker issues one more read for the page entry. Memory is reached through a plain read port: the walker raises a request with a word-aligned byte address and waits for a valid strobe carrying 32 bits of data.

When the walk ends, `done` pulses for one cycle. The result outputs then give the physical address, a page type code, the 4-bit domain, the cacheable/bufferable pair and the access-permission bits, or they report a translation fault. A static configuration input says whether fine tables and tiny pages are supported. Only one walk runs at a time. The results stay on the outputs until the next walk finishes.

Top module: `pt_walker`

## Requirements
- R1: The first read goes to the address formed from base bits 31:14, then virtual bits 31:20, then two zero bits. Every request address is word aligned.
- R2: A first-level entry with bits 1:0 = 10 ends the walk after one read. The results are: physical address = entry bits 31:20 joined with virtual bits 19:0, type code 0, cb = entry bits 3:2, ap = entry bits 11:10 zero-extended to 8 bits.
- R3: On every walk that does not fault, the domain output equals first-level entry bits 8:5.
- R4: A first-level entry with bits 1:0 = 01 (coarse) causes a second read. Its address is entry bits 31:10, then virtual bits 19:12, then two zero bits.
- R5: A first-level entry with bits 1:0 = 11 (fine), with tiny support on, causes a second read. Its address is entry bits 31:12, then virtual bits 19:10, then two zero bits.
- R6: A first-level entry with bits 1:0 = 00 ends the walk after one read with a fault.
- R7: A fine first-level entry with tiny support off ends the walk after one read with a fault.
- R8: A second-level entry with bits 1:0 = 00 ends the walk with a fault.
- R9: A second-level entry with bits 1:0 = 01 gives type code 1, physical address = entry bits 31:16 joined with virtual bits 15:0, ap = entry bits 11:4, cb = entry bits 3:2.
- R10: A second-level entry with bits 1:0 = 10 gives type code 2, physical address = entry bits 31:12 joined with virtual bits 11:0, ap = entry bits 11:4, cb = entry bits 3:2.
- R11: A second-level entry with bits 1:0 = 11 gives type code 3, physical address = entry bits 31:10 joined with virtual bits 9:0, ap = entry bits 5:4 zero-extended, cb = entry bits 3:2.
- R12: After reset, `busy`, `done` and `mem_req` are low and the type code is 7. `mem_req` stays high with a stable address until `mem_valid` arrives. `busy` is high from the cycle after `start` is accepted until the walk ends. `done` is a one-cycle pulse.
- R13: `start` has no effect while `busy` is high. The result outputs do not change between `done` pulses. A fault gives fault = 1, type code 7, and zero physical address, domain, cb and ap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tiny_en | input | 1 | Fine tables and tiny pages are supported |
| start | input | 1 | Begin a walk (accepted only when idle) |
| vaddr | input | 32 | Virtual address to translate |
| tbase | input | 32 | Translation table base |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when the walk ends |
| fault | output | 1 | Translation fault on the last walk |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor byte address, word aligned |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| pa | output | 32 | Physical address |
| ptype | output | 3 | Page type: 0 section, 1 large, 2 small, 3 tiny, 7 none |
| domain | output | 4 | Domain field |
| cb | output | 2 | Cacheable/bufferable bits |
| ap | output | 8 | Access-permission bits |

## Verification
The walker is tried with a section entry and with coarse tables that end in large and small pages. It is also tried with fine tables that end in tiny and small pages. Each result proves that the right slice of the virtual address and of each entry was used. The same fine entry is then walked with tiny support off, and separately entries of type 00 are walked at both levels. These runs tell a fault raised at the first level (one read) from one raised at the second level (two reads), and confirm that the fault result is all zero. Memory latency varies from zero to three cycles. Directed runs cover the reset values, a `start` pulse during a walk, and the holding of the results after `done`.

// File: rtl/pt_walk_pkg.sv
// Shared widths, codes and the result record of the page table walker.
// Assumes 32-bit addresses and 32-bit descriptors.
package pt_walk_pkg;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned DOM_W   = 4;
    localparam int unsigned CB_W    = 2;
    localparam int unsigned AP_W    = 8;
    localparam int unsigned TYPE_W  = 3;
    localparam int unsigned SEC_LO  = 20;   // offset bits inside a section
    localparam int unsigned LRG_LO  = 16;   // offset bits inside a large page
    localparam int unsigned SML_LO  = 12;   // offset bits inside a small page
    localparam int unsigned TNY_LO  = 10;   // offset bits inside a tiny page
    localparam int unsigned BASE_LO = 14;   // table base alignment

    typedef enum logic [TYPE_W-1:0] {
        PG_SECTION = 3'd0,
        PG_LARGE   = 3'd1,
        PG_SMALL   = 3'd2,
        PG_TINY    = 3'd3,
        PG_NONE    = 3'd7
    } page_t;

    typedef enum logic [1:0] {
        K_FAULT  = 2'b00,
        K_KIND_A = 2'b01,   // level 1: coarse table, level 2: large page
        K_KIND_B = 2'b10,   // level 1: section,      level 2: small page
        K_KIND_C = 2'b11    // level 1: fine table,   level 2: tiny page
    } kind_t;

    typedef struct packed {
        logic              fault;
        logic [ADDR_W-1:0] pa;
        page_t             ptype;
        logic [DOM_W-1:0]  dom;
        logic [CB_W-1:0]   cb;
        logic [AP_W-1:0]   ap;
    } walk_res_t;

    localparam walk_res_t RES_FAULT = '{fault: 1'b1, pa: '0, ptype: PG_NONE,
                                        dom: '0, cb: '0, ap: '0};
    localparam walk_res_t RES_IDLE  = '{fault: 1'b0, pa: '0, ptype: PG_NONE,
                                        dom: '0, cb: '0, ap: '0};
endpackage

// File: rtl/pt_desc_addr.sv
// Forms the byte addresses of the first- and second-level descriptors.
// Assumes the level-1 pointer field is valid only after the first read.
module pt_desc_addr
    import pt_walk_pkg::*;
(
    input  logic [ADDR_W-1:BASE_LO] tbase_hi,
    input  logic [ADDR_W-1:SEC_LO]  va_hi,
    input  logic [SEC_LO-1:TNY_LO]  va_mid,
    input  logic [ADDR_W-1:TNY_LO]  l1_ptr,
    input  logic                    l1_fine,
    output logic [ADDR_W-1:0]       l1_addr,
    output logic [ADDR_W-1:0]       l2_addr
);
    // level 1: table base joined with the section index, word scaled
    assign l1_addr = {tbase_hi, va_hi, 2'b00};

    // level 2: coarse tables index by 4 KB page, fine tables by 1 KB page
    always_comb begin
        if (l1_fine)
            l2_addr = {l1_ptr[ADDR_W-1:SML_LO], va_mid, 2'b00};
        else
            l2_addr = {l1_ptr, va_mid[SEC_LO-1:SML_LO], 2'b00};
    end
endmodule

// File: rtl/pt_l1_decode.sv
// Decodes a first-level descriptor: says whether the walk ends here
// (section or fault) and builds that result. Combinational.
module pt_l1_decode
    import pt_walk_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [SEC_LO-1:0] va_lo,
    input  logic              tiny_en,
    output logic              ends,
    output walk_res_t         res
);
    kind_t kind;
    logic  unused_bits;

    assign kind        = kind_t'(desc[1:0]);
    assign unused_bits = ^{desc[SEC_LO-1:12], desc[9], desc[4]};

    // classify the entry and assemble a section or fault result
    always_comb begin
        ends = 1'b0;
        res  = RES_IDLE;
        unique case (kind)
            K_FAULT: begin
                ends = 1'b1;
                res  = RES_FAULT;
            end
            K_KIND_B: begin
                ends      = 1'b1;
                res.pa    = {desc[ADDR_W-1:SEC_LO], va_lo};
                res.ptype = PG_SECTION;
                res.dom   = desc[8:5];
                res.cb    = desc[3:2];
                res.ap    = {{(AP_W-2){1'b0}}, desc[11:10]};
            end
            K_KIND_C: begin
                if (!tiny_en) begin
                    ends = 1'b1;
                    res  = RES_FAULT;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pt_l2_decode.sv
// Decodes a second-level descriptor into a page result or a fault.
// The domain is carried in from the first-level entry. Combinational.
module pt_l2_decode
    import pt_walk_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [LRG_LO-1:0] va_lo,
    input  logic [DOM_W-1:0]  dom_in,
    output walk_res_t         res
);
    kind_t kind;
    assign kind = kind_t'(desc[1:0]);

    // pick page size, offset slice and permission width by entry kind
    always_comb begin
        res     = RES_IDLE;
        res.dom = dom_in;
        res.cb  = desc[3:2];
        unique case (kind)
            K_FAULT:  res = RES_FAULT;
            K_KIND_A: begin
                res.pa    = {desc[ADDR_W-1:LRG_LO], va_lo};
                res.ptype = PG_LARGE;
                res.ap    = desc[11:4];
            end
            K_KIND_B: begin
                res.pa    = {desc[ADDR_W-1:SML_LO], va_lo[SML_LO-1:0]};
                res.ptype = PG_SMALL;
                res.ap    = desc[11:4];
            end
            default: begin
                res.pa    = {desc[ADDR_W-1:TNY_LO], va_lo[TNY_LO-1:0]};
                res.ptype = PG_TINY;
                res.ap    = {{(AP_W-2){1'b0}}, desc[5:4]};
            end
        endcase
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker. One walk at a time; each descriptor read
// holds mem_req until mem_valid. Results are registered and held until the
// next walk ends. Assumes memory answers every request eventually.
module pt_walker
    import pt_walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tiny_en,
    input  logic              start,
    input  logic [31:0]       vaddr,
    input  logic [31:0]       tbase,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_valid,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       pa,
    output logic [2:0]        ptype,
    output logic [3:0]        domain,
    output logic [1:0]        cb,
    output logic [7:0]        ap
);
    typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2} st_t;

    st_t                     state;
    logic [ADDR_W-1:0]       va_q;
    logic [ADDR_W-1:BASE_LO] tb_q;
    logic [ADDR_W-1:0]       l1_q;
    logic                    done_q;
    walk_res_t               res_q;
    logic [ADDR_W-1:0]       l1_addr, l2_addr;
    logic                    l1_ends;
    walk_res_t               l1_res, l2_res;
    logic                    unused_l1;

    assign unused_l1 = ^{l1_q[9], l1_q[4:2], l1_q[0]};

    pt_desc_addr u_addr (
        .tbase_hi (tb_q),
        .va_hi    (va_q[ADDR_W-1:SEC_LO]),
        .va_mid   (va_q[SEC_LO-1:TNY_LO]),
        .l1_ptr   (l1_q[ADDR_W-1:TNY_LO]),
        .l1_fine  (l1_q[1]),
        .l1_addr  (l1_addr),
        .l2_addr  (l2_addr)
    );

    pt_l1_decode u_l1 (
        .desc    (mem_rdata),
        .va_lo   (va_q[SEC_LO-1:0]),
        .tiny_en (tiny_en),
        .ends    (l1_ends),
        .res     (l1_res)
    );

    pt_l2_decode u_l2 (
        .desc   (mem_rdata),
        .va_lo  (va_q[LRG_LO-1:0]),
        .dom_in (l1_q[8:5]),
        .res    (l2_res)
    );

    // walk sequencer: accept, read level 1, optionally read level 2, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            va_q   <= '0;
            tb_q   <= '0;
            l1_q   <= '0;
            done_q <= 1'b0;
            res_q  <= RES_IDLE;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    va_q  <= vaddr;
                    tb_q  <= tbase[ADDR_W-1:BASE_LO];
                    state <= ST_L1;
                end
                ST_L1: if (mem_valid) begin
                    if (l1_ends) begin
                        res_q  <= l1_res;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        l1_q  <= mem_rdata;
                        state <= ST_L2;
                    end
                end
                default: if (mem_valid) begin
                    res_q  <= l2_res;
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
            endcase
        end
    end

    // port mapping of state and held result
    assign busy     = (state != ST_IDLE);
    assign mem_req  = busy;
    assign mem_addr = (state == ST_L2) ? l2_addr : l1_addr;
    assign done     = done_q;
    assign fault    = res_q.fault;
    assign pa       = res_q.pa;
    assign ptype    = res_q.ptype;
    assign domain   = res_q.dom;
    assign cb       = res_q.cb;
    assign ap       = res_q.ap;

    // R12: an unanswered request keeps its address
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr));
    // R12: done lasts one cycle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1: descriptor reads are word aligned
    p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);
    // R13: a fault result is all zero with the none code
    p_fault_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> pa == '0 && ptype == PG_NONE && ap == '0);
    // R2: a successful walk reports a real page type
    p_ok_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> ptype != PG_NONE);
    // R13: results do not move between done pulses
    p_res_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(pa) && $stable(ptype));
    // R11: tiny pages report only two permission bits
    p_tiny_ap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done && ptype == PG_TINY |-> ap[7:2] == '0);
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
    typedef struct packed {
        logic [31:0] va, tb, l1, l2;
        logic        tiny;
        logic [1:0]  lat;
        logic        flt;
        logic [31:0] pa;
        logic [2:0]  ty;
        logic [3:0]  dom;
        logic [1:0]  cb;
        logic [7:0]  ap;
        logic [1:0]  nrd;
        logic [31:0] a1, a2;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'hABC12345, 32'h12345678, 32'h876009EE, 32'h0, 1'b1, 2'd0, 1'b0,
          32'h87612345, 3'd0, 4'hF, 2'd3, 8'h02, 2'd1, 32'h12346AF0, 32'h0},
        '{32'hABC12345, 32'h12345678, 32'h555554A1, 32'hCAFE0A55, 1'b1, 2'd1, 1'b0,
          32'hCAFE2345, 3'd1, 4'h5, 2'd1, 8'hA5, 2'd2, 32'h12346AF0, 32'h55555448},
        '{32'hABC12345, 32'h12345678, 32'h555554A1, 32'h135793CA, 1'b0, 2'd2, 1'b0,
          32'h13579345, 3'd2, 4'h5, 2'd2, 8'h3C, 2'd2, 32'h12346AF0, 32'h55555448},
        '{32'hABC12345, 32'h12345678, 32'h2468A143, 32'h99999FDF, 1'b1, 2'd3, 1'b0,
          32'h99999F45, 3'd3, 4'hA, 2'd3, 8'h01, 2'd2, 32'h12346AF0, 32'h2468A120},
        '{32'hABC12345, 32'h12345678, 32'h2468A143, 32'h99999FDF, 1'b0, 2'd0, 1'b1,
          32'h0, 3'd7, 4'h0, 2'd0, 8'h00, 2'd1, 32'h12346AF0, 32'h0},
        '{32'hABC12345, 32'h12345678, 32'hFFFFFFFC, 32'h0, 1'b1, 2'd1, 1'b1,
          32'h0, 3'd7, 4'h0, 2'd0, 8'h00, 2'd1, 32'h12346AF0, 32'h0},
        '{32'hABC12345, 32'h12345678, 32'h555554A1, 32'hFFFFFFF0, 1'b1, 2'd2, 1'b1,
          32'h0, 3'd7, 4'h0, 2'd0, 8'h00, 2'd2, 32'h12346AF0, 32'h55555448},
        '{32'hABC12345, 32'h12345678, 32'h2468A143, 32'h00001FF2, 1'b1, 2'd0, 1'b0,
          32'h00001345, 3'd2, 4'hA, 2'd0, 8'hFF, 2'd2, 32'h12346AF0, 32'h2468A120},
        '{32'h00000FFF, 32'hFFFFFFFF, 32'h00000002, 32'h0, 1'b0, 2'd3, 1'b0,
          32'h00000FFF, 3'd0, 4'h0, 2'd0, 8'h00, 2'd1, 32'hFFFFC000, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tiny_en = 1'b0;
    logic        start = 1'b0;
    logic [31:0] vaddr = '0, tbase = '0;
    logic        busy, done, fault, mem_req;
    logic [31:0] mem_addr, pa;
    logic        mem_valid;
    logic [31:0] mem_rdata;
    logic [2:0]  ptype;
    logic [3:0]  domain;
    logic [1:0]  cb;
    logic [7:0]  ap;

    logic [31:0] m_l1 = '0, m_l2 = '0;
    logic [1:0]  m_lat = '0;
    logic [1:0]  m_wait;
    int          n_rd;
    logic [31:0] rd_a1, rd_a2;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .tiny_en(tiny_en), .start(start),
        .vaddr(vaddr), .tbase(tbase), .busy(busy), .done(done), .fault(fault),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .pa(pa), .ptype(ptype), .domain(domain),
        .cb(cb), .ap(ap)
    );

    // memory model: answers each request after m_lat idle cycles, logs addresses
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            mem_rdata <= '0;
            m_wait    <= '0;
            n_rd      <= 0;
            rd_a1     <= '0;
            rd_a2     <= '0;
        end else if (start && !busy) begin
            n_rd      <= 0;
            mem_valid <= 1'b0;
            m_wait    <= '0;
        end else if (mem_req && !mem_valid) begin
            if (m_wait == m_lat) begin
                mem_valid <= 1'b1;
                mem_rdata <= (n_rd == 0) ? m_l1 : m_l2;
                if (n_rd == 0) rd_a1 <= mem_addr; else rd_a2 <= mem_addr;
                n_rd      <= n_rd + 1;
                m_wait    <= '0;
            end else begin
                m_wait <= m_wait + 2'd1;
            end
        end else begin
            mem_valid <= 1'b0;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] tb, input logic [31:0] l1,
                        input logic [31:0] l2, input logic tiny, input logic [1:0] lat);
        m_l1 = l1; m_l2 = l2; m_lat = lat;
        @(negedge clk);
        vaddr = va; tbase = tb; tiny_en = tiny; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string rq);
        int n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(rq, {31'b0, done}, 32'd1);
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0: return "R2";  1: return "R9";  2: return "R10";
            3: return "R11"; 4: return "R7";  5: return "R6";
            6: return "R8";  7: return "R5";  default: return "R2";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R12: reset state
        chk("R12 busy", {31'b0, busy}, 32'd0);
        chk("R12 done", {31'b0, done}, 32'd0);
        chk("R12 req", {31'b0, mem_req}, 32'd0);
        chk("R12 ptype", {29'b0, ptype}, 32'd7);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            walk(VECS[i].va, VECS[i].tb, VECS[i].l1, VECS[i].l2, VECS[i].tiny, VECS[i].lat);
            wait_done("R12 done");
            chk(tag_of(i), {31'b0, fault}, {31'b0, VECS[i].flt});
            chk(tag_of(i), pa, VECS[i].pa);
            chk(tag_of(i), {29'b0, ptype}, {29'b0, VECS[i].ty});
            chk(VECS[i].flt ? "R13" : "R3", {28'b0, domain}, {28'b0, VECS[i].dom});
            chk(tag_of(i), {30'b0, cb}, {30'b0, VECS[i].cb});
            chk(tag_of(i), {24'b0, ap}, {24'b0, VECS[i].ap});
            chk(tag_of(i), n_rd, {30'b0, VECS[i].nrd});
            chk("R1", rd_a1, VECS[i].a1);
            if (VECS[i].nrd == 2'd2)
                chk((i == 1 || i == 2 || i == 6) ? "R4" : "R5", rd_a2, VECS[i].a2);
            @(negedge clk);
        end

        // R13: start during a walk is ignored; R12: busy after accept
        walk(VECS[1].va, VECS[1].tb, VECS[1].l1, VECS[1].l2, 1'b1, 2'd3);
        chk("R12 busy", {31'b0, busy}, 32'd1);
        vaddr = 32'h0; tbase = 32'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R12 done");
        chk("R13 pa", pa, 32'hCAFE2345);
        chk("R13 reads", n_rd, 32'd2);
        chk("R13 addr", rd_a1, 32'h12346AF0);

        // R13: results hold after done; R12: done falls, busy low
        repeat (4) @(negedge clk);
        chk("R13 hold", pa, 32'hCAFE2345);
        chk("R13 hold", {24'b0, ap}, 32'hA5);
        chk("R12 done", {31'b0, done}, 32'd0);
        chk("R12 busy", {31'b0, busy}, 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule